// File: doc/BRIEF.md
# Phase Angle Estimator for I/Q Vectors

This block takes a signed in-phase/quadrature sample pair and returns the angle of that vector as a signed whole number of degrees. The angle is measured counter-clockwise from the positive in-phase axis and lies in the range -180 to +180. In a linearised transmitter, two copies run side by side: one measures the phase of the forward baseband vector and the other measures the phase of the demodulated feedback vector. Forming the difference of the two angles, and wrapping it, happens outside this block.

The angle is produced in four steps. First, both components are reduced to magnitudes. The smaller magnitude becomes the numerator and the larger becomes the denominator, and a flag records whether the two were exchanged. Second, a pipelined restoring divider forms the ratio, producing one quotient bit per stage. Third, the ratio addresses a one-degree arctangent table that covers only the first octant. Fourth, the exchange flag and the two input signs map the octant angle back onto the full circle.

The block accepts a new vector on every clock cycle. Results leave in input order, each after a fixed delay.

Top module: `atan_est`

## Requirements
- R1: While `rstN` is low, and on the first sampled cycle after it, `outValid` is 0 and `outAngle` is 0. Vectors that were in flight when reset was asserted produce no result.
- R2: Each cycle with `inValid` high yields exactly one cycle with `outValid` high, FRAC_W+3 clock edges later (11 at default parameters), in the same order. A cycle with `inValid` low yields a cycle with `outValid` low at the matching position, so back-to-back vectors and gaps are both preserved.
- R3: The divider always receives the smaller magnitude as numerator, so the ratio never exceeds 1. When |Q| > |I|, the octant angle is replaced by 90 minus the table value. Vectors in all eight octants are therefore within 1 degree of the true angle.
- R4: A zero-length vector (I = Q = 0) yields exactly 0. The zero denominator it produces does not fault; instead the divider quotient saturates to all ones.
- R5: Quadrant selection uses the signs of I and Q, taken as two's complement sign bits. Q >= 0 gives an angle in [0, 180] and Q < 0 gives an angle in [-180, 0]. The axis points give exactly 0 for (+,0), 90 for (0,+), 180 for (-,0) and -90 for (0,-).
- R6: `outAngle` is a signed integer number of degrees. For any non-zero input, it is within 1 degree of atan2(Q, I), where +180 and -180 are treated as the same angle. It never leaves the range [-180, 180].
- R7: Vectors with |I| = |Q| give exactly 45, 135, -135 or -45, according to their quadrant.
- R8: Full-scale inputs, including the most negative code -2^(DATA_W-1) on either component, are handled without overflow and still meet R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Marks a vector on `inI`/`inQ` this cycle |
| inI | input | DATA_W | In-phase component, two's complement |
| inQ | input | DATA_W | Quadrature component, two's complement |
| outValid | output | 1 | Marks a result on `outAngle` this cycle |
| outAngle | output | ANG_W | Vector angle in degrees, two's complement |

## Verification
The in-line properties are checked on every cycle:
- a zero-length vector drives the last divider stage to an all-ones quotient and the output to 0;
- the ratio reaching the table never exceeds one for a non-zero vector;
- the sign of the result follows the sign of Q;
- a valid output stays within [-180, 180].

Only the bench scenarios can show the rest: that each octant, after the exchange and quadrant mapping, lands within a degree of the true angle; that the latency and the position of gaps are exact; and that a reset in the middle of a stream leaves no stray result behind.

// File: rtl/atan_est_pkg.sv
package atan_est_pkg;

  // Per-cycle load strobes from the control section to the datapath.
  typedef struct packed {
    logic foldEn;    // capture a new input vector into the fold stage
    logic lookupEn;  // capture the unfolded angle into the output register
  } stepStrobes_t;

  // Octant arctangent, in whole degrees, of the ratio k/n for 0 <= k <= n.
  // A rational approximation is evaluated in scaled integers and then rounded.
  // Its error before rounding stays below a tenth of a degree.
  function automatic int unsigned atanDegEntry(input int unsigned k, input int unsigned n);
    logic [63:0] kk;
    logic [63:0] nn;
    logic [63:0] num;
    logic [63:0] den;
    kk  = 64'(k);
    nn  = 64'(n);
    num = 64'd45000 * kk * nn * nn
        + kk * (nn - kk) * (64'd14020 * nn + 64'd3799 * kk);
    den = 64'd1000 * nn * nn * nn;
    return 32'((num + (den >> 1)) / den);
  endfunction

endpackage

// File: rtl/atan_est_ctrl.sv
module atan_est_ctrl
  import atan_est_pkg::*;
#(
  parameter int STAGES = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output stepStrobes_t      strobes,
  output logic [STAGES-1:0] divEn,
  output logic              outValid
);

  localparam int DEPTH = STAGES + 2;

  // Position 0: fold stage. Positions 1..STAGES: divider stages. Position STAGES+1: output.
  logic [DEPTH-1:0] stageValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= '0;
    end else begin
      stageValid <= {stageValid[DEPTH-2:0], inValid};
    end
  end

  always_comb begin
    strobes.foldEn   = inValid;
    strobes.lookupEn = stageValid[STAGES];
    divEn            = stageValid[STAGES-1:0];
    outValid         = stageValid[DEPTH-1];
  end

endmodule

// File: rtl/atan_est_datapath.sv
module atan_est_datapath
  import atan_est_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int FRAC_W = 8,
  parameter int ANG_W  = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stepStrobes_t             strobes,
  input  logic [FRAC_W:0]          divEn,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic signed [ANG_W-1:0]  outAngle
);

  localparam int QW    = FRAC_W + 1;     // one integer bit plus the fraction bits
  localparam int REM_W = DATA_W + 1;     // room for a left-shifted partial remainder
  localparam int N_ENT = 1 << FRAC_W;    // quotient code that stands for a ratio of 1.0
  localparam logic signed [ANG_W-1:0] DEG90  = ANG_W'(90);
  localparam logic signed [ANG_W-1:0] DEG180 = ANG_W'(180);

  // ---------------- fold: magnitudes, ordering, sign capture ----------------
  logic [DATA_W-1:0] absI, absQ;
  logic              swapNow;

  always_comb begin
    absI    = inI[DATA_W-1] ? DATA_W'(-inI) : DATA_W'(inI);
    absQ    = inQ[DATA_W-1] ? DATA_W'(-inQ) : DATA_W'(inQ);
    swapNow = absQ > absI;
  end

  // Stage registers. Index 0 holds the fold result; index j+1 holds divider step j.
  logic [REM_W-1:0]  dRem [QW];
  logic [DATA_W-1:0] dDen [QW];
  logic [QW-1:0]     dQuo [QW+1];
  logic [QW:0]       dSwap, dNegI, dNegQ, dZero;

  // ---------------- restoring divider: one quotient bit per stage ----------------
  logic [REM_W-1:0] shf     [QW];
  logic [REM_W-1:0] nextRem [QW];
  logic [QW-1:0]    stepBit;

  always_comb begin
    for (int j = 0; j < QW; j++) begin
      shf[j]     = (j == 0) ? dRem[j] : {dRem[j][REM_W-2:0], 1'b0};
      stepBit[j] = shf[j] >= {1'b0, dDen[j]};
      nextRem[j] = stepBit[j] ? (shf[j] - {1'b0, dDen[j]}) : shf[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < QW; j++) begin
        dRem[j] <= '0;
        dDen[j] <= '0;
      end
      for (int j = 0; j <= QW; j++) begin
        dQuo[j] <= '0;
      end
      dSwap <= '0;
      dNegI <= '0;
      dNegQ <= '0;
      dZero <= '0;
    end else begin
      if (strobes.foldEn) begin
        dRem[0]  <= REM_W'(swapNow ? absI : absQ);
        dDen[0]  <= swapNow ? absQ : absI;
        dQuo[0]  <= '0;
        dSwap[0] <= swapNow;
        dNegI[0] <= inI[DATA_W-1];
        dNegQ[0] <= inQ[DATA_W-1];
        dZero[0] <= (absI == '0) && (absQ == '0);
      end
      for (int j = 0; j < QW; j++) begin
        if (divEn[j]) begin
          if (j + 1 < QW) begin
            dRem[j+1] <= nextRem[j];
            dDen[j+1] <= dDen[j];
          end
          dQuo[j+1]  <= {dQuo[j][QW-2:0], stepBit[j]};
          dSwap[j+1] <= dSwap[j];
          dNegI[j+1] <= dNegI[j];
          dNegQ[j+1] <= dNegQ[j];
          dZero[j+1] <= dZero[j];
        end
      end
    end
  end

  // ---------------- first-octant arctangent table, one-degree entries ----------------
  logic [ANG_W-1:0] atanTab [N_ENT+1];

  for (genvar k = 0; k <= N_ENT; k++) begin : g_tab
    assign atanTab[k] = ANG_W'(atanDegEntry(k, N_ENT));
  end

  // ---------------- unfold: octant, then quadrant ----------------
  logic [QW-1:0]           tabIdx;
  logic signed [ANG_W-1:0] baseA, octA, nextAngle;

  always_comb begin
    tabIdx = (dQuo[QW] > QW'(N_ENT)) ? QW'(N_ENT) : dQuo[QW];
    baseA  = $signed(atanTab[tabIdx]);
    octA   = dSwap[QW] ? (DEG90 - baseA) : baseA;
    if (dZero[QW]) begin
      nextAngle = '0;
    end else begin
      case ({dNegI[QW], dNegQ[QW]})
        2'b00:   nextAngle = octA;
        2'b10:   nextAngle = DEG180 - octA;
        2'b11:   nextAngle = octA - DEG180;
        default: nextAngle = -octA;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAngle <= '0;
    end else if (strobes.lookupEn) begin
      outAngle <= nextAngle;
    end
  end

  // R4
  div_zero_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (divEn[QW-1] && dZero[QW-1]) |=> (dQuo[QW] == {QW{1'b1}}));

  // R3
  ratio_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lookupEn && !dZero[QW]) |-> (dQuo[QW] <= QW'(N_ENT)));

  // R4
  zero_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lookupEn && dZero[QW]) |=> (outAngle == '0));

  // R5
  upper_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lookupEn && !dNegQ[QW]) |=> (outAngle >= 0));

  // R5
  lower_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lookupEn && dNegQ[QW]) |=> (outAngle <= 0));

endmodule

// File: rtl/atan_est.sv
module atan_est
  import atan_est_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int FRAC_W = 8,
  parameter int ANG_W  = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic                     outValid,
  output logic signed [ANG_W-1:0]  outAngle
);

  localparam int STAGES = FRAC_W + 1;

  stepStrobes_t      strobes;
  logic [STAGES-1:0] divEn;

  atan_est_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .divEn    (divEn),
    .outValid (outValid)
  );

  atan_est_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ANG_W(ANG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .divEn    (divEn),
    .inI      (inI),
    .inQ      (inQ),
    .outAngle (outAngle)
  );

  // R6
  angle_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outAngle >= -ANG_W'(180)) && (outAngle <= ANG_W'(180))));

endmodule

// File: tb/atan_est_tb.sv
`timescale 1ns/1ps
module atan_est_tb;

  localparam int  DW  = 12;
  localparam int  FW  = 8;
  localparam int  AW  = 9;
  localparam int  LAT = FW + 3;
  localparam int  NV  = 25;
  localparam real PI  = 3.14159265358979;

  // Stimulus table: I, Q, valid, tolerance in degrees (0 = exact).
  localparam int VI  [NV] = '{100, 0, -100, 0, 50, -50, -50, 50, 0,
                              1000, 300, -300, -1000, -1000, -300, 300, 1000,
                              0, -2048, 2047, -2048, -2048, 1, 0, 1234};
  localparam int VQ  [NV] = '{0, 100, 0, -100, 50, 50, -50, -50, 0,
                              300, 1000, 1000, 300, -300, -1000, -1000, -300,
                              0, -2048, -2048, 1, -1, 2047, 0, -567};
  localparam int VV  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1,
                              1, 1, 1, 1, 1, 1, 1, 1,
                              0, 1, 1, 1, 1, 1, 1, 1};
  localparam int TOL [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0,
                              1, 1, 1, 1, 1, 1, 1, 1,
                              0, 0, 1, 1, 1, 1, 0, 1};

  logic                 clk = 1'b0;
  logic                 rstN;
  logic                 inValid;
  logic signed [DW-1:0] inI, inQ;
  logic                 outValid;
  logic signed [AW-1:0] outAngle;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  atan_est #(.DATA_W(DW), .FRAC_W(FW), .ANG_W(AW)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inI      (inI),
    .inQ      (inQ),
    .outValid (outValid),
    .outAngle (outAngle)
  );

  function automatic string reqTag(input int e);
    if (e < 4)                  return "R5";
    else if (e < 8)             return "R7";
    else if (e == 8 || e == 23) return "R4";
    else if (e < 17)            return "R3";
    else if (e < 23)            return "R8";
    else                        return "R6";
  endfunction

  task automatic checkEq(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAng(input string tag, input int act, input real expv, input real tol);
    real d;
    d = real'(act) - expv;
    while (d > 180.0)  d = d - 360.0;
    while (d < -180.0) d = d + 360.0;
    nChecks++;
    if (d > tol + 0.01 || d < -(tol + 0.01)) begin
      nFail++;
      $display("FAIL %s angle: actual %0d expected %f (tol %f)", tag, act, expv, tol);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    int firstSeen;
    rstN    = 1'b0;
    inValid = 1'b0;
    inI     = '0;
    inQ     = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkEq("R1", "outValid in reset", int'(outValid), 0);
    checkEq("R1", "outAngle in reset", int'(outAngle), 0);
    rstN = 1'b1;

    // Table walk: one vector per cycle, sampled LAT cycles after its drive.
    for (int t = 0; t < NV + LAT + 2; t++) begin
      int e;
      int expV;
      @(negedge clk);
      e    = t - LAT;
      expV = (e >= 0 && e < NV) ? VV[e] : 0;
      // R2: valid position follows input order and gaps
      checkEq("R2", "outValid", int'(outValid), expV);
      if (expV == 1 && outValid) begin
        checkAng(reqTag(e), int'(outAngle),
                 $atan2(real'(VQ[e]), real'(VI[e])) * 180.0 / PI, real'(TOL[e]));
      end
      if (t < NV) begin
        inValid = (VV[t] != 0);
        inI     = DW'(VI[t]);
        inQ     = DW'(VQ[t]);
      end else begin
        inValid = 1'b0;
      end
    end

    // R2: isolated vector appears after exactly LAT edges
    @(negedge clk);
    inValid = 1'b1; inI = -12'sd300; inQ = -12'sd1000;
    firstSeen = -1;
    for (int n = 1; n <= LAT + 3; n++) begin
      @(negedge clk);
      inValid = 1'b0;
      if (outValid && firstSeen < 0) begin
        firstSeen = n;
        checkAng("R2", int'(outAngle), $atan2(-1000.0, -300.0) * 180.0 / PI, 1.0);
      end
    end
    checkEq("R2", "latency", firstSeen, LAT);

    // R1: reset mid-stream discards in-flight vectors
    inValid = 1'b1; inI = 12'sd300; inQ = 12'sd1000;
    repeat (3) @(negedge clk);
    inValid = 1'b0;
    rstN    = 1'b0;
    @(negedge clk);
    checkEq("R1", "outValid after mid-stream reset", int'(outValid), 0);
    checkEq("R1", "outAngle after mid-stream reset", int'(outAngle), 0);
    rstN = 1'b1;
    for (int n = 0; n < LAT + 2; n++) begin
      @(negedge clk);
      checkEq("R1", "no stray result after reset", int'(outValid), 0);
    end

    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R2 watchdog: actual run still active, expected completion");
    finishRun();
  end

endmodule